// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Target Controller

This block is the digital front end of a 1 Kbyte serial EEPROM that answers on a two-wire I2C bus. It runs on a fast system clock and oversamples the bus clock and data lines. It finds START and STOP conditions and frames the bits into bytes. The storage is four 256-byte blocks. The select byte that follows every START carries a fixed device-type nibble, one bit compared against a chip-enable strap, two block bits and the direction bit. The block bits become the upper two bits of the 10-bit memory address, so two devices with opposite straps can share one bus.

After a write select, the next byte sets the low eight address bits. Each later byte is handed to a byte-wide memory port at an address that counts up by one. After a read select, bytes are fetched from that port starting at the current address. Data goes out on SDA through an open-drain enable, `sda_oe` (1 pulls the line low). Changes on that enable are held back a fixed number of clocks after SCL falls. A STOP that closes a write starts a programming interval, and the device ignores selects during it. The interval doubles when the written bytes cover more than one 8-byte row.

Top module: `eeprom_i2c_target`

## Requirements
- R1: A select byte whose four most significant bits are not 1010 is not acknowledged, and the device leaves SDA released until the next START.
- R2: Select bit 3 (bit order 7..0, bit 7 first on the wire) must equal `chip_en`; on a mismatch the device does not acknowledge.
- R3: Select bits 2:1 give the block number and form `mem_addr[9:8]` for every access that follows the select.
- R4: Select bit 0 sets the direction: 0 means write and 1 means read. A matching select is acknowledged by driving `sda_oe` high during the ninth clock.
- R5: In a write, the first byte after the select is the low address byte. Every later byte is acknowledged and produces one single-cycle `mem_we` pulse with that byte at the current address. The address then steps up by one.
- R6: A START at any point, including in the middle of a byte, restarts decoding of a new select byte (repeated START).
- R7: `sda_oe` never changes earlier than HOLD_CYCLES clock cycles after SCL falls at the pin, and it never starts driving while SCL is high.
- R8: A STOP that arrives on a byte boundary after at least one written data byte starts a busy interval of BUSY_CYCLES clocks. No select byte is acknowledged during that interval.
- R9: When the bytes written in one transfer fall into more than one 8-byte row (address bits 9:3 differ), the busy interval is 2*BUSY_CYCLES.
- R10: In a read, the device sends the byte at the current address, MSB first, and then steps the address. It goes on after a master ACK (SDA low in the ninth clock), releases SDA after a NACK, and keeps the address for the next transfer.
- R11: A STOP inside a byte aborts the transfer. No partial byte is written and no busy interval starts.
- R12: After reset, `sda_oe` and `mem_we` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| chip_en | input | 1 | Chip-enable strap compared with select bit 3 |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| mem_addr | output | 10 | Memory port address |
| mem_we | output | 1 | Memory write strobe, one cycle per byte |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, registered one cycle after `mem_addr` |

## Verification
The bench builds the block with BUSY_CYCLES=1000, HOLD_CYCLES=3, SYNC_STAGES=2 and the default 8-byte row. The short busy count lets a select land inside the single interval, between the single and the doubled interval, and after both, so each length can be told apart from the others. The 3-cycle hold with a 10-clock quarter bit period leaves a clear margin between the delayed SDA updates and the next SCL edge, and every SDA change can be timed against the last SCL fall.

// File: rtl/eeprom_i2c_pkg.sv
`timescale 1ns/1ps
package eeprom_i2c_pkg;
  localparam int ADDR_W = 10;
  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEL,
    ST_ADDR,
    ST_WDATA,
    ST_RDATA
  } ctl_state_t;
endpackage

// File: rtl/eeprom_i2c_line_sync.sv
`timescale 1ns/1ps
module eeprom_i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_d    <= 1'b1;
      sda_d    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_d    <= scl_pipe[STAGES-1];
      sda_d    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  // data edges while the clock stays high mark bus conditions
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/eeprom_sda_driver.sv
`timescale 1ns/1ps
module eeprom_sda_driver #(
  parameter int HOLD_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic value,
  input  logic release_now,
  output logic sda_oe
);
  localparam int CW = $clog2(HOLD_CYCLES + 1);

  logic [CW-1:0] dly;
  logic          pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      sda_oe <= 1'b0;
      dly    <= '0;
      pend   <= 1'b0;
    end else if (release_now) begin
      sda_oe <= 1'b0;
      dly    <= '0;
    end else if (load) begin
      pend <= value;
      dly  <= CW'(HOLD_CYCLES);
    end else if (dly != '0) begin
      dly <= dly - 1'b1;
      if (dly == CW'(1)) sda_oe <= pend;
    end
  end

  // R7: a fresh drive request never reaches the pad on the next cycle
  a_r7_no_early_drive: assert property (@(posedge clk) disable iff (rst)
    load |=> (sda_oe == $past(sda_oe)) || !sda_oe);
endmodule

// File: rtl/eeprom_write_timer.sv
`timescale 1ns/1ps
module eeprom_write_timer #(
  parameter int BUSY_CYCLES = 1250000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic dbl,
  output logic busy
);
  localparam int CW = $clog2(2 * BUSY_CYCLES + 1);

  logic [CW-1:0] left;

  always_ff @(posedge clk) begin
    if (rst) begin
      left <= '0;
    end else if (start) begin
      left <= dbl ? CW'(2 * BUSY_CYCLES) : CW'(BUSY_CYCLES);
    end else if (left != '0) begin
      left <= left - 1'b1;
    end
  end

  assign busy = (left != '0);

  // R8: the busy interval only ever opens on a programming request
  a_r8_busy_from_start: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/eeprom_i2c_target.sv
`timescale 1ns/1ps
module eeprom_i2c_target
  import eeprom_i2c_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 4,
  parameter int BUSY_CYCLES = 1250000,
  parameter int ROW_BYTES   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic              chip_en,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int ROW_LSB = $clog2(ROW_BYTES);
  localparam int ROW_W   = ADDR_W - ROW_LSB;

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic busy;

  ctl_state_t        st;
  logic [3:0]        cnt;
  logic [7:0]        sh;
  logic [7:0]        tx;
  logic              rw;
  logic              ack_m;
  logic [ADDR_W-1:0] addr;
  logic              wrote;
  logic              span;
  logic [ROW_W-1:0]  first_row;
  logic              drv_load, drv_val, drv_rel;
  logic              tmr_start, tmr_dbl;

  eeprom_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  eeprom_sda_driver #(.HOLD_CYCLES(HOLD_CYCLES)) u_drv (
    .clk(clk), .rst(rst), .load(drv_load), .value(drv_val),
    .release_now(drv_rel), .sda_oe(sda_oe)
  );

  eeprom_write_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_tmr (
    .clk(clk), .rst(rst), .start(tmr_start), .dbl(tmr_dbl), .busy(busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      cnt       <= '0;
      sh        <= '0;
      tx        <= '0;
      rw        <= 1'b0;
      ack_m     <= 1'b0;
      addr      <= '0;
      wrote     <= 1'b0;
      span      <= 1'b0;
      first_row <= '0;
      drv_load  <= 1'b0;
      drv_val   <= 1'b0;
      drv_rel   <= 1'b0;
      tmr_start <= 1'b0;
      tmr_dbl   <= 1'b0;
      mem_addr  <= '0;
      mem_we    <= 1'b0;
      mem_wdata <= '0;
    end else begin
      mem_we    <= 1'b0;
      drv_load  <= 1'b0;
      drv_rel   <= 1'b0;
      tmr_start <= 1'b0;
      mem_addr  <= addr;
      if (start_det) begin
        st      <= ST_SEL;
        cnt     <= '0;
        drv_rel <= 1'b1;
        wrote   <= 1'b0;
        span    <= 1'b0;
      end else if (stop_det) begin
        // a STOP just after the first clock of a new byte closes the write
        if (st == ST_WDATA && cnt == 4'd1 && wrote) begin
          tmr_start <= 1'b1;
          tmr_dbl   <= span;
        end
        st      <= ST_IDLE;
        cnt     <= '0;
        drv_rel <= 1'b1;
        wrote   <= 1'b0;
        span    <= 1'b0;
      end else if (st != ST_IDLE) begin
        if (scl_rise) begin
          cnt <= cnt + 1'b1;
          if (cnt < 4'd8) sh <= {sh[6:0], sda_s};
          else            ack_m <= ~sda_s;
        end else if (scl_fall) begin
          if (cnt == 4'd8) begin
            // ninth clock: acknowledge slot
            case (st)
              ST_SEL: begin
                if (sh[7:4] == DEV_TYPE && sh[3] == chip_en && !busy) begin
                  rw         <= sh[0];
                  addr[9:8]  <= sh[2:1];
                  drv_load   <= 1'b1;
                  drv_val    <= 1'b1;
                end else begin
                  st <= ST_IDLE;
                end
              end
              ST_ADDR: begin
                addr[7:0] <= sh;
                drv_load  <= 1'b1;
                drv_val   <= 1'b1;
              end
              ST_WDATA: begin
                mem_we    <= 1'b1;
                mem_wdata <= sh;
                addr      <= addr + 1'b1;
                wrote     <= 1'b1;
                if (!wrote) first_row <= addr[ADDR_W-1:ROW_LSB];
                else if (addr[ADDR_W-1:ROW_LSB] != first_row) span <= 1'b1;
                drv_load  <= 1'b1;
                drv_val   <= 1'b1;
              end
              ST_RDATA: begin
                addr     <= addr + 1'b1;
                drv_load <= 1'b1;
                drv_val  <= 1'b0;
              end
              default: ;
            endcase
          end else if (cnt == 4'd9) begin
            cnt <= '0;
            case (st)
              ST_SEL: begin
                drv_load <= 1'b1;
                if (rw) begin
                  st      <= ST_RDATA;
                  tx      <= mem_rdata;
                  drv_val <= ~mem_rdata[7];
                end else begin
                  st      <= ST_ADDR;
                  drv_val <= 1'b0;
                end
              end
              ST_ADDR: begin
                st       <= ST_WDATA;
                drv_load <= 1'b1;
                drv_val  <= 1'b0;
              end
              ST_WDATA: begin
                drv_load <= 1'b1;
                drv_val  <= 1'b0;
              end
              ST_RDATA: begin
                drv_load <= 1'b1;
                if (ack_m) begin
                  tx      <= mem_rdata;
                  drv_val <= ~mem_rdata[7];
                end else begin
                  st      <= ST_IDLE;
                  drv_val <= 1'b0;
                end
              end
              default: ;
            endcase
          end else if (st == ST_RDATA && cnt != 4'd0) begin
            tx       <= {tx[6:0], 1'b0};
            drv_load <= 1'b1;
            drv_val  <= ~tx[6];
          end
        end
      end
    end
  end

  // R7: the target never starts pulling SDA low while SCL is high
  a_r7_drive_scl_low: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_s);

  // R5: every byte write is a single-cycle strobe
  a_r5_we_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> !mem_we);

  // R5: the address steps by one after each written byte
  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> mem_addr == $past(mem_addr) + 10'd1);

  // R8: while programming, select decoding never drives the bus
  a_r8_busy_no_ack: assert property (@(posedge clk) disable iff (rst)
    (busy && st == ST_SEL) |-> !sda_oe);
endmodule

// File: tb/eeprom_i2c_target_tb_top.sv
`timescale 1ns/1ps
module eeprom_i2c_target_tb_top;
  localparam int Q    = 10;
  localparam int HOLD = 3;
  localparam int BUSY = 1000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       sda_m = 1'b1;
  logic       chip_en = 1'b1;
  logic       sda_oe;
  logic [9:0] mem_addr;
  logic       mem_we;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata;
  wire        sda_line = sda_m & ~sda_oe;

  always #4 clk = ~clk;

  eeprom_i2c_target #(
    .SYNC_STAGES(2), .HOLD_CYCLES(HOLD), .BUSY_CYCLES(BUSY), .ROW_BYTES(8)
  ) dut_i (
    .clk(clk), .rst(rst), .scl_i(scl), .sda_i(sda_line), .chip_en(chip_en),
    .sda_oe(sda_oe), .mem_addr(mem_addr), .mem_we(mem_we),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // storage array standing in for the cells
  logic [7:0] cells [1024];
  // independent model of the expected content
  int model [1024];
  int exp_q[$];
  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int t_fall = 0;
  bit scl_prev = 1'b1;
  bit oe_prev = 1'b0;
  bit done = 1'b0;

  initial begin
    for (int i = 0; i < 1024; i++) begin
      cells[i] = 8'((i * 37 + 11) & 255);
      model[i] = (i * 37 + 11) & 255;
    end
  end

  always @(posedge clk) begin
    if (mem_we) cells[mem_addr] <= mem_wdata;
    mem_rdata <= cells[mem_addr];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // per-clock monitor: write port against expected queue, SDA timing
  always @(negedge clk) begin
    cyc++;
    if (scl_prev && !scl) t_fall = cyc;
    scl_prev = scl;
    if (!rst && sda_oe !== oe_prev) begin
      if (!scl) chk(cyc - t_fall >= HOLD, "R7 hold after SCL fall", cyc - t_fall, HOLD);
      else if (sda_oe) chk(1'b0, "R7 drive while SCL high", 1, 0);
      oe_prev = sda_oe;
    end
    if (!rst && mem_we) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected write", int'(mem_addr), -1);
      else begin
        int e;
        e = exp_q.pop_front();
        chk({22'd0, mem_addr, mem_wdata} == e, "R3 R5 write addr/data",
            int'({mem_addr, mem_wdata}), e);
      end
    end
    if (cyc > 150000 && !done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic tx_bit(input logic b);
    sda_m = b; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0; wq();
  endtask

  task automatic rx_bit(output logic b);
    sda_m = 1'b1; wq(); scl = 1'b1; wq(); b = sda_line; wq(); scl = 1'b0; wq();
  endtask

  task automatic tx_byte(input logic [7:0] d, output bit ack);
    logic b;
    for (int i = 7; i >= 0; i--) tx_bit(d[i]);
    rx_bit(b);
    ack = (b == 1'b0);
  endtask

  task automatic rx_byte(output logic [7:0] d, input bit mack);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      rx_bit(b);
      d[i] = b;
    end
    tx_bit(!mack);
  endtask

  function automatic logic [7:0] sel(input logic e, input logic [1:0] blk, input logic rd);
    return {4'b1010, e, blk, rd};
  endfunction

  task automatic wr_byte_exp(input int a, input logic [7:0] d);
    bit ack;
    exp_q.push_back((a << 8) | int'(d));
    model[a] = int'(d);
    tx_byte(d, ack);
    chk(ack, "R5 data ack", int'(ack), 1);
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    repeat (10) @(negedge clk);
    chk(sda_oe == 1'b0, "R12 sda_oe reset", int'(sda_oe), 0);
    chk(mem_we == 1'b0, "R12 mem_we reset", int'(mem_we), 0);
    rst = 1'b0;
    repeat (10) @(negedge clk);

    // R1: wrong type nibble
    bus_start();
    tx_byte(8'hB2, ack);
    chk(!ack, "R1 wrong type not acked", int'(ack), 0);
    tx_byte(8'h00, ack);
    chk(!ack, "R1 transfer ignored", int'(ack), 0);
    bus_stop();

    // R2: chip-enable compare
    bus_start();
    tx_byte(sel(1'b0, 2'd0, 1'b0), ack);
    chk(!ack, "R2 enable mismatch", int'(ack), 0);
    bus_stop();
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    chk(ack, "R2 enable match", int'(ack), 1);
    bus_stop();

    // R3 R4 R5: write three bytes in block 2
    bus_start();
    tx_byte(sel(1'b1, 2'd2, 1'b0), ack);
    chk(ack, "R4 write select ack", int'(ack), 1);
    tx_byte(8'h35, ack);
    chk(ack, "R5 address ack", int'(ack), 1);
    wr_byte_exp(10'h235, 8'h11);
    wr_byte_exp(10'h236, 8'h22);
    wr_byte_exp(10'h237, 8'h33);
    bus_stop();
    // R8: busy right after the write
    bus_start();
    tx_byte(sel(1'b1, 2'd2, 1'b0), ack);
    chk(!ack, "R8 busy select not acked", int'(ack), 0);
    bus_stop();
    repeat (BUSY) @(negedge clk);

    // R6 R10: dummy write then repeated START read
    bus_start();
    tx_byte(sel(1'b1, 2'd2, 1'b0), ack);
    chk(ack, "R8 ack after single interval", int'(ack), 1);
    tx_byte(8'h35, ack);
    bus_start();
    tx_byte(sel(1'b1, 2'd2, 1'b1), ack);
    chk(ack, "R6 repeated start read select", int'(ack), 1);
    rx_byte(d, 1'b1);
    chk(int'(d) == model[10'h235], "R10 read byte 0", int'(d), model[10'h235]);
    rx_byte(d, 1'b1);
    chk(int'(d) == model[10'h236], "R10 read byte 1", int'(d), model[10'h236]);
    rx_byte(d, 1'b0);
    chk(int'(d) == model[10'h237], "R10 read byte 2", int'(d), model[10'h237]);
    chk(sda_oe == 1'b0, "R10 release after NACK", int'(sda_oe), 0);
    bus_stop();

    // R10: current address continues in a new transfer
    bus_start();
    tx_byte(sel(1'b1, 2'd2, 1'b1), ack);
    rx_byte(d, 1'b0);
    chk(int'(d) == model[10'h238], "R10 current address read", int'(d), model[10'h238]);
    bus_stop();

    // R3: same low address, other block
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    tx_byte(8'h35, ack);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b1), ack);
    rx_byte(d, 1'b0);
    chk(int'(d) == model[10'h035], "R3 block 0 read", int'(d), model[10'h035]);
    bus_stop();

    // R9: write across an 8-byte row boundary
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    tx_byte(8'h06, ack);
    wr_byte_exp(10'h006, 8'hA1);
    wr_byte_exp(10'h007, 8'hA2);
    wr_byte_exp(10'h008, 8'hA3);
    bus_stop();
    repeat (BUSY) @(negedge clk);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    chk(!ack, "R9 still busy past single interval", int'(ack), 0);
    bus_stop();
    repeat (BUSY) @(negedge clk);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    chk(ack, "R9 ack after doubled interval", int'(ack), 1);
    bus_stop();

    // R11: STOP inside a data byte
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    tx_byte(8'h40, ack);
    tx_bit(1'b0); tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bus_stop();
    chk(exp_q.size() == 0, "R11 no partial write", exp_q.size(), 0);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b0), ack);
    chk(ack, "R11 no busy after abort", int'(ack), 1);
    tx_byte(8'h40, ack);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b1), ack);
    rx_byte(d, 1'b0);
    chk(int'(d) == model[10'h040], "R11 cell unchanged", int'(d), model[10'h040]);
    bus_stop();

    // R6: START inside a select byte
    bus_start();
    tx_bit(1'b1); tx_bit(1'b0); tx_bit(1'b1);
    bus_start();
    tx_byte(sel(1'b1, 2'd0, 1'b1), ack);
    chk(ack, "R6 mid-byte start restarts", int'(ack), 1);
    rx_byte(d, 1'b0);
    chk(int'(d) == model[10'h041], "R6 read after restart", int'(d), model[10'h041]);
    bus_stop();

    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule